// File: doc/BRIEF.md
# Self-Synchronizing Multiplicative Scrambler

This block whitens or restores a serial bit stream with the recursive polynomial 1 + x^12 + x^17. It processes one bit per accepted clock and holds a 17-stage history of channel bits, meaning the bits that travel on the line. In scramble mode the history is fed with the block's own output. In descramble mode it is fed with the received bits. In both modes the output bit is the incoming bit XORed with the history taps at delays 12 and 17.

Because the history holds past line bits rather than a free-running sequence, a receiver needs no frame alignment. Once 17 clean line bits have entered the history, the descrambled output is correct, whatever state the history held before. The cost of this is error multiplication: one corrupted line bit is seen three times, once directly and once at each tap.

A mode input chooses the direction bit by bit. A valid strobe gates every state change. A synchronous reset clears the history.

Top module: `selfsync_scrambler`

## Requirements
- R1: A synchronous reset clears the history to all zeros and drives `dout` and `dout_valid` low. After a reset, scrambling an all-zero input gives an all-zero output.
- R2: With `mode`=0 (scramble), each accepted bit gives y = x ^ y(n-12) ^ y(n-17), where y(n-k) is the k-th most recent output bit. The output bit y is shifted into the history.
- R3: With `mode`=1 (descramble), each accepted bit gives x = y ^ y(n-12) ^ y(n-17). Here the received bit y is shifted into the history, so descrambling a scrambled stream from the same reset state returns the original data.
- R4: Each result appears on `dout`, with `dout_valid` high, on the clock edge that accepts the input bit. Outputs are read one cycle after the bit is driven.
- R5: While `din_valid` is low, the history does not shift, `dout` keeps its last value and `dout_valid` is low. A gapped stream therefore gives the same result bits as an unbroken one.
- R6: Starting from any history contents and with no reset, the descrambler's output equals the original data from the 18th bit of a scrambled stream onward.
- R7: A single flipped line bit at position p gives exactly three errors at the descrambler output, at positions p, p+12 and p+17.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0 = scramble, 1 = descramble |
| din | input | 1 | Serial input bit |
| din_valid | input | 1 | Input bit is accepted this cycle |
| dout | output | 1 | Serial result bit |
| dout_valid | output | 1 | Result bit is new this cycle |

## Verification
The hardest condition to reach from the ports is a descrambler whose history is unrelated to the incoming stream. Reset always zeroes the history, so that state cannot be loaded directly. The bench first pushes junk bits through the descrambler without a reset, then presents a properly scrambled stream and checks only the bits from the 18th onward. Error multiplication is provoked by flipping one line bit far enough inside a long stream that both of its delayed copies land within the stream, and then checking the exact positions of the output errors.

// File: rtl/scr_pkg.sv
package scr_pkg;
   typedef enum logic {
      SCR_DIR_WHITEN  = 1'b0,
      SCR_DIR_RESTORE = 1'b1
   } scr_dir_e;
endpackage

// File: rtl/scr_history.sv
module scr_history #(
   parameter int DEPTH = 17
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_en,
   input  logic             line_bit,
   output logic [DEPTH-1:0] hist
);
   // hist[0] is the newest line bit, hist[DEPTH-1] the oldest
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("scr_history: DEPTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)           hist <= '0;
      else if (shift_en) hist <= {hist[DEPTH-2:0], line_bit};
   end

   assert_clear_on_reset_R1: assert property (@(posedge clk)
      rst |=> hist == '0);

   assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(hist));

   assert_shift_order_R2: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> hist[DEPTH-1:1] == $past(hist[DEPTH-2:0]));
endmodule

// File: rtl/scr_tap_xor.sv
module scr_tap_xor #(
   parameter int DEPTH = 17,
   parameter int TAP_NEAR = 12,
   parameter int TAP_FAR = 17
) (
   input  logic [DEPTH-1:0] hist,
   output logic             fb
);
   localparam logic [DEPTH-1:0] SEL_MASK =
      (DEPTH'(1) << (TAP_NEAR - 1)) | (DEPTH'(1) << (TAP_FAR - 1));

   generate
      if (TAP_NEAR < 1 || TAP_NEAR >= TAP_FAR || TAP_FAR > DEPTH) begin : g_bad_taps
         $error("scr_tap_xor: taps must satisfy 1 <= TAP_NEAR < TAP_FAR <= DEPTH");
      end
   endgenerate

   logic [DEPTH-1:0] picked;
   for (genvar i = 0; i < DEPTH; i++) begin : g_pick
      assign picked[i] = hist[i] & SEL_MASK[i];
   end

   assign fb = ^picked;
endmodule

// File: rtl/selfsync_scrambler.sv
module selfsync_scrambler #(
   parameter int TAP_NEAR = 12,
   parameter int TAP_FAR  = 17,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic mode,
   input  logic din,
   input  logic din_valid,
   output logic dout,
   output logic dout_valid
);
   import scr_pkg::*;

   localparam int DEPTH = TAP_FAR;

   scr_dir_e          dir;
   logic [DEPTH-1:0]  hist;
   logic              fb;
   logic              res_bit;
   logic              line_bit;

   assign dir      = scr_dir_e'(mode);
   assign res_bit  = din ^ fb;
   // whitening feeds back its own output; restoring feeds back the received bit
   assign line_bit = (dir == SCR_DIR_RESTORE) ? din : res_bit;

   scr_history #(.DEPTH(DEPTH)) u_hist (
      .clk      (clk),
      .rst      (rst),
      .shift_en (din_valid),
      .line_bit (line_bit),
      .hist     (hist)
   );

   scr_tap_xor #(.DEPTH(DEPTH), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_taps (
      .hist (hist),
      .fb   (fb)
   );

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk) begin
            if (rst) begin
               dout       <= 1'b0;
               dout_valid <= 1'b0;
            end else begin
               dout_valid <= din_valid;
               if (din_valid) dout <= res_bit;
            end
         end

         assert_valid_follows_R4: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> dout_valid == $past(din_valid));

         assert_out_enters_hist_R2: assert property (@(posedge clk) disable iff (rst)
            (din_valid && mode == 1'b0) |=> dout == hist[0]);

         assert_rx_enters_hist_R3: assert property (@(posedge clk) disable iff (rst)
            (din_valid && mode == 1'b1) |=> hist[0] == $past(din));

         assert_dout_holds_R5: assert property (@(posedge clk) disable iff (rst)
            !din_valid |=> $stable(dout));
      end else begin : g_comb_out
         assign dout       = res_bit;
         assign dout_valid = din_valid;
      end
   endgenerate
endmodule

// File: tb/sim_selfsync_scrambler.sv
`timescale 1ns/1ps
module sim_selfsync_scrambler;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mode = 1'b0;
   logic din = 1'b0;
   logic din_valid = 1'b0;
   logic dout, dout_valid;

   int checks = 0;
   int failures = 0;
   logic [16:0] mh;
   logic xbuf [0:127];
   logic ybuf [0:127];

   typedef struct packed {
      logic [31:0] pat;
      logic        zero_out;
   } vec_t;

   localparam vec_t VEC_TBL [6] = '{
      '{32'h0000_0000, 1'b1},
      '{32'hFFFF_FFFF, 1'b0},
      '{32'h5555_5555, 1'b0},
      '{32'h1ACF_FC1D, 1'b0},
      '{32'h8000_0001, 1'b0},
      '{32'hDEAD_BEEF, 1'b0}
   };

   always #4 clk = ~clk;

   selfsync_scrambler u0 (
      .clk(clk), .rst(rst), .mode(mode), .din(din),
      .din_valid(din_valid), .dout(dout), .dout_valid(dout_valid)
   );

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // reference model from the equations in R2/R3
   task automatic mstep(input logic m, input logic b, output logic o);
      o  = b ^ mh[11] ^ mh[16];
      mh = {mh[15:0], (m ? b : o)};
   endtask

   // inputs change at a falling edge; the result is read at the next falling edge
   task automatic step(input logic m, input logic b, input logic v);
      mode = m; din = b; din_valid = v;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1; din_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      mh = '0;
   endtask

   initial begin
      logic e, b;
      int mism, gapbad, ones, nerr;
      logic held;
      logic err30, err42, err47;

      @(negedge clk);
      do_reset();
      // R1: reset state
      chk(dout === 1'b0, "R1", "dout after reset", int'(dout), 0);
      chk(dout_valid === 1'b0, "R1", "dout_valid after reset", int'(dout_valid), 0);

      // table walk: R2 scramble against model, R3 round trip, R1 zero in zero out
      for (int t = 0; t < 6; t++) begin
         do_reset();
         mism = 0; ones = 0;
         for (int i = 0; i < 64; i++) begin
            b = VEC_TBL[t].pat[31 - (i % 32)];
            xbuf[i] = b;
            mstep(1'b0, b, e);
            step(1'b0, b, 1'b1);
            ybuf[i] = dout;
            if (dout !== e || dout_valid !== 1'b1) mism++;
            if (dout === 1'b1) ones++;
         end
         chk(mism == 0, "R2", $sformatf("scramble mismatches vec %0d", t), mism, 0);
         if (VEC_TBL[t].zero_out)
            chk(ones == 0, "R1", "ones from zero input after reset", ones, 0);
         do_reset();
         mism = 0;
         for (int i = 0; i < 64; i++) begin
            step(1'b1, ybuf[i], 1'b1);
            if (dout !== xbuf[i]) mism++;
         end
         chk(mism == 0, "R3", $sformatf("round trip mismatches vec %0d", t), mism, 0);
      end

      // R4/R5: gapped stream
      do_reset();
      mism = 0; gapbad = 0;
      for (int i = 0; i < 40; i++) begin
         b = logic'(i % 2) ^ logic'((i / 3) % 2);
         mstep(1'b0, b, e);
         step(1'b0, b, 1'b1);
         if (dout !== e || dout_valid !== 1'b1) mism++;
         if (i % 5 == 4) begin
            held = dout;
            for (int k = 0; k < 3; k++) begin
               step(1'b0, logic'(k % 2), 1'b0);
               if (dout !== held || dout_valid !== 1'b0) gapbad++;
            end
         end
      end
      chk(mism == 0, "R4", "gapped stream result/valid mismatches", mism, 0);
      chk(gapbad == 0, "R5", "idle cycles that changed outputs", gapbad, 0);

      // R6: self-sync from arbitrary history
      do_reset();
      for (int i = 0; i < 64; i++) begin
         b = 32'h1ACF_FC1D >> (31 - (i % 32));
         xbuf[i] = b;
         mstep(1'b0, b, e);
         ybuf[i] = e;
      end
      for (int i = 0; i < 23; i++) step(1'b1, logic'(i % 3 == 0), 1'b1);
      mism = 0;
      for (int i = 0; i < 64; i++) begin
         step(1'b1, ybuf[i], 1'b1);
         if (i >= 17 && dout !== xbuf[i]) mism++;
      end
      chk(mism == 0, "R6", "mismatches from bit 18 on", mism, 0);

      // R7: single line error multiplied into three
      do_reset();
      for (int i = 0; i < 80; i++) begin
         b = 32'hDEAD_BEEF >> (31 - (i % 32));
         xbuf[i] = b;
         mstep(1'b0, b, e);
         ybuf[i] = e;
      end
      ybuf[30] = ~ybuf[30];
      do_reset();
      nerr = 0; err30 = 0; err42 = 0; err47 = 0;
      for (int i = 0; i < 80; i++) begin
         step(1'b1, ybuf[i], 1'b1);
         if (dout !== xbuf[i]) begin
            nerr++;
            if (i == 30) err30 = 1;
            if (i == 42) err42 = 1;
            if (i == 47) err47 = 1;
         end
      end
      chk(nerr == 3, "R7", "output error count", nerr, 3);
      chk(err30 && err42 && err47, "R7", "errors at 30/42/47",
          int'({err30, err42, err47}), 7);

      summary();
      $finish;
   end
endmodule